// File: doc/BRIEF.md
# SCSI controller register and interrupt unit

This block is the byte-wide register file of a SCSI protocol controller. A processor reaches it over a simple strobe bus. The slot index is the bus address shifted right by a configurable amount, so the sixteen slots can sit on byte, half-word or word boundaries. At several offsets a read and a write reach different registers. A read returns status, interrupt cause, sequence step or FIFO flags. A write at the same offset lands in a write-side copy, which the command and DMA logic elsewhere consume through `wshadow_o`.

The status, interrupt-cause, sequence-step and FIFO-flag registers are changed by the neighbouring command and transfer blocks through set, clear and load strobes. They are also changed by the processor through one read side effect: acknowledging the interrupt cause. The block drives one level interrupt that follows the interrupt flag in status. It supports an asynchronous hard reset and a synchronous soft reset from an external input. Writes that decode beyond the sixteen slots are dropped and latch a sticky error flag.

Top module: `scsi_regfile_irq`

## Requirements
- R1: The slot index is `bus_addr >> ADDR_SHIFT` (ADDR_SHIFT = 2 by default). Address bits below the shift are ignored, and indices 0 to 15 are valid slots.
- R2: After hard reset every readable slot returns 0x00, except slot 8, which reads 0x07, and slot 14, which reads 0x04. `irq_o`, `err_o` and all of `wshadow_o` are 0.
- R3: Slot 4 reads status, slot 5 reads interrupt cause, slot 6 reads sequence step and slot 7 reads FIFO flags. Writes to slots 4 to 7, 9 and 10 change only the write-side copy: byte k of `wshadow_o` (bits 8k+7:8k) holds the last write to slot k, and the read side is unchanged.
- R4: A write to slot 3, 8, 11, 12, 13, 14 or 15 appears both in the readable slot and in the write-side copy from the next cycle.
- R5: Writes to slot 0 or 1 update only the write-side copy and clear status bit 4. A `tc_reload` pulse copies write-side bytes 0 and 1, as held before that edge, into readable slots 0 and 1.
- R6: A read of slot 5 returns the cause value held before the read. In the next cycle the cause is 0x00, status bits 7 and 4 are 0, the sequence step is 0x04 and `irq_o` is low.
- R7: `irq_o` rises only when status bit 7 goes from 0 to 1 and falls only when it goes from 1 to 0. Setting the bit while it is already set leaves `irq_o` high.
- R8: The event strobes are applied after the bus side effects of the same cycle: `status = (status & ~ev_stat_clr) | ev_stat_set`, `cause |= ev_intr_set`, and the sequence step and flags load their values when their load strobe is high.
- R9: `soft_rst` high at a clock edge drops `irq_o` and returns all state to the R2 values. It overrides bus accesses and events in that cycle.
- R10: A write whose index is 16 or more changes no register and sets `err_o`, which stays set until a reset. A read with such an index returns 0x00 and has no side effect.
- R11: A read of slot 2 returns `fifo_rdata`. Slots 9 and 10 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state on rising edge |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| bus_addr | input | ADDR_W | Bus byte address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed slot (combinational) |
| fifo_rdata | input | 8 | Byte returned for reads of slot 2 |
| ev_stat_set | input | 8 | Status bits to set |
| ev_stat_clr | input | 8 | Status bits to clear |
| ev_intr_set | input | 8 | Interrupt-cause bits to set |
| ev_seq_load | input | 1 | Load the sequence step |
| ev_seq_val | input | 8 | Sequence step value |
| ev_flags_load | input | 1 | Load the FIFO flags |
| ev_flags_val | input | 8 | FIFO flags value |
| tc_reload | input | 1 | Copy write-side count bytes into readable slots 0 and 1 |
| irq_o | output | 1 | Level interrupt request |
| err_o | output | 1 | Sticky out-of-range write flag |
| wshadow_o | output | 128 | Write-side copies, byte k for slot k |

## Verification
The first pattern is a reset sweep over all sixteen slots. It tells the two non-zero reset constants apart from the zero slots, and it shows that the slot-5 read already moves the sequence step. Next, a write sweep puts a distinct byte into every slot and reads all of them back. This separates slots whose writes are visible from those kept only on the write side, and it checks every byte position of `wshadow_o`. Event patterns then raise and lower the interrupt, including a repeated set and an acknowledge that coincides with a new event, to tell edge following from simple clearing. Out-of-range sweeps over every index from 16 to 63, and a soft reset issued together with a write and an event, check that nothing leaks through.

// File: rtl/sri_pkg.sv
package sri_pkg;
  localparam int unsigned NSLOT = 16;
  localparam int unsigned DW    = 8;

  localparam int unsigned OFS_CNT_LO = 0;
  localparam int unsigned OFS_CNT_MD = 1;
  localparam int unsigned OFS_FIFO   = 2;
  localparam int unsigned OFS_STAT   = 4;
  localparam int unsigned OFS_CAUSE  = 5;
  localparam int unsigned OFS_STEP   = 6;
  localparam int unsigned OFS_FLAGS  = 7;
  localparam int unsigned OFS_CONF_A = 8;
  localparam int unsigned OFS_CNT_HI = 14;

  localparam int unsigned BIT_IRQ = 7;
  localparam int unsigned BIT_TC  = 4;

  localparam logic [DW-1:0] ID_CODE    = 8'h04;
  localparam logic [DW-1:0] CONF_A_RST = 8'h07;
  localparam logic [DW-1:0] STEP_ACK   = 8'h04;

  typedef enum logic [1:0] {
    SK_SHADOW,   // write side only, read side fixed or owned elsewhere
    SK_BOTH,     // write lands in both copies
    SK_COUNT     // write side only, read side loaded by reload strobe
  } slot_kind_e;

  function automatic slot_kind_e slot_kind(input int unsigned ofs);
    if (ofs == OFS_CNT_LO || ofs == OFS_CNT_MD) return SK_COUNT;
    if (ofs == 3 || ofs == OFS_CONF_A || ofs >= 11) return SK_BOTH;
    return SK_SHADOW;
  endfunction

  function automatic logic [DW-1:0] slot_reset(input int unsigned ofs);
    if (ofs == OFS_CNT_HI) return ID_CODE;
    if (ofs == OFS_CONF_A) return CONF_A_RST;
    return '0;
  endfunction

  function automatic logic [DW-1:0] stat_after(input logic [DW-1:0] cur,
                                               input logic ack,
                                               input logic cnt_wr,
                                               input logic [DW-1:0] set,
                                               input logic [DW-1:0] clr);
    logic [DW-1:0] s;
    s = cur;
    if (ack) begin
      s[BIT_IRQ] = 1'b0;
      s[BIT_TC]  = 1'b0;
    end
    if (cnt_wr) s[BIT_TC] = 1'b0;
    return (s & ~clr) | set;
  endfunction
endpackage

// File: rtl/sri_addr_decode.sv
module sri_addr_decode #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned ADDR_SHIFT = 2,
  parameter int unsigned IDX_W      = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic              in_range
);
  import sri_pkg::*;
  logic [ADDR_W-1:0] full_idx;

  assign full_idx = addr >> ADDR_SHIFT;
  assign in_range = (full_idx < ADDR_W'(NSLOT));
  assign idx      = full_idx[IDX_W-1:0];
endmodule

// File: rtl/sri_slot_bank.sv
module sri_slot_bank #(
  parameter int unsigned IDX_W = 4
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      soft_rst,
  input  logic                                      wr_en,
  input  logic [IDX_W-1:0]                          idx,
  input  logic [sri_pkg::DW-1:0]                    wdata,
  input  logic                                      tc_reload,
  output logic [sri_pkg::NSLOT-1:0][sri_pkg::DW-1:0] copy_o,
  output logic [sri_pkg::NSLOT-1:0][sri_pkg::DW-1:0] shadow_o
);
  import sri_pkg::*;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    localparam slot_kind_e    KIND = slot_kind(g);
    localparam logic [DW-1:0] RVAL = slot_reset(g);
    logic          hit;
    logic [DW-1:0] shadow_q;

    assign hit = wr_en && (idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        shadow_q <= '0;
      else if (soft_rst) shadow_q <= '0;
      else if (hit)      shadow_q <= wdata;
    end
    assign shadow_o[g] = shadow_q;

    if (KIND == SK_BOTH) begin : g_both
      logic [DW-1:0] copy_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        copy_q <= RVAL;
        else if (soft_rst) copy_q <= RVAL;
        else if (hit)      copy_q <= wdata;
      end
      assign copy_o[g] = copy_q;
    end else if (KIND == SK_COUNT) begin : g_count
      logic [DW-1:0] copy_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         copy_q <= RVAL;
        else if (soft_rst)  copy_q <= RVAL;
        else if (tc_reload) copy_q <= shadow_q;
      end
      assign copy_o[g] = copy_q;
    end else begin : g_fixed
      assign copy_o[g] = RVAL;
    end
  end
endmodule

// File: rtl/sri_status_ctl.sv
module sri_status_ctl (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   soft_rst,
  input  logic                   ack_rd,
  input  logic                   cnt_wr,
  input  logic [sri_pkg::DW-1:0] ev_stat_set,
  input  logic [sri_pkg::DW-1:0] ev_stat_clr,
  input  logic [sri_pkg::DW-1:0] ev_intr_set,
  input  logic                   ev_seq_load,
  input  logic [sri_pkg::DW-1:0] ev_seq_val,
  input  logic                   ev_flags_load,
  input  logic [sri_pkg::DW-1:0] ev_flags_val,
  output logic [sri_pkg::DW-1:0] stat_q,
  output logic [sri_pkg::DW-1:0] cause_q,
  output logic [sri_pkg::DW-1:0] step_q,
  output logic [sri_pkg::DW-1:0] flags_q,
  output logic                   irq_o
);
  import sri_pkg::*;
  logic [DW-1:0] stat_d, cause_d, step_d, flags_d;
  logic          irq_raise, irq_lower, irq_q;

  always_comb begin
    stat_d  = stat_after(stat_q, ack_rd, cnt_wr, ev_stat_set, ev_stat_clr);
    cause_d = (ack_rd ? '0 : cause_q) | ev_intr_set;
    step_d  = ev_seq_load ? ev_seq_val : (ack_rd ? STEP_ACK : step_q);
    flags_d = ev_flags_load ? ev_flags_val : flags_q;
  end

  // interrupt line moves only on edges of the status flag
  assign irq_raise = !stat_q[BIT_IRQ] &&  stat_d[BIT_IRQ];
  assign irq_lower =  stat_q[BIT_IRQ] && !stat_d[BIT_IRQ];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0; cause_q <= '0; step_q <= '0; flags_q <= '0; irq_q <= 1'b0;
    end else if (soft_rst) begin
      stat_q <= '0; cause_q <= '0; step_q <= '0; flags_q <= '0; irq_q <= 1'b0;
    end else begin
      stat_q  <= stat_d;
      cause_q <= cause_d;
      step_q  <= step_d;
      flags_q <= flags_d;
      if (irq_raise)      irq_q <= 1'b1;
      else if (irq_lower) irq_q <= 1'b0;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/scsi_regfile_irq.sv
module scsi_regfile_irq #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned ADDR_SHIFT = 2
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  soft_rst,
  input  logic [ADDR_W-1:0]                     bus_addr,
  input  logic                                  bus_rd,
  input  logic                                  bus_wr,
  input  logic [7:0]                            bus_wdata,
  output logic [7:0]                            bus_rdata,
  input  logic [7:0]                            fifo_rdata,
  input  logic [7:0]                            ev_stat_set,
  input  logic [7:0]                            ev_stat_clr,
  input  logic [7:0]                            ev_intr_set,
  input  logic                                  ev_seq_load,
  input  logic [7:0]                            ev_seq_val,
  input  logic                                  ev_flags_load,
  input  logic [7:0]                            ev_flags_val,
  input  logic                                  tc_reload,
  output logic                                  irq_o,
  output logic                                  err_o,
  output logic [sri_pkg::NSLOT*sri_pkg::DW-1:0] wshadow_o
);
  import sri_pkg::*;
  localparam int unsigned IDX_W = $clog2(NSLOT);

  logic [IDX_W-1:0]            idx;
  logic                        in_range;
  logic                        wr_en;
  logic [NSLOT-1:0][DW-1:0]    copy_v, shadow_v;
  logic [DW-1:0]               stat_q, cause_q, step_q, flags_q;
  logic                        err_q;

  // named events, observed by the bound checker
  logic ack_rd_ev, cnt_wr_ev, oor_wr_ev, ro_wr_ev;

  sri_addr_decode #(.ADDR_W(ADDR_W), .ADDR_SHIFT(ADDR_SHIFT), .IDX_W(IDX_W)) u_dec (
    .addr(bus_addr), .idx(idx), .in_range(in_range)
  );

  assign wr_en     = bus_wr && in_range;
  assign ack_rd_ev = bus_rd && in_range && (idx == IDX_W'(OFS_CAUSE));
  assign cnt_wr_ev = wr_en && (idx == IDX_W'(OFS_CNT_LO) || idx == IDX_W'(OFS_CNT_MD));
  assign oor_wr_ev = bus_wr && !in_range;
  assign ro_wr_ev  = wr_en && (idx >= IDX_W'(OFS_STAT)) && (idx <= IDX_W'(OFS_FLAGS));

  sri_slot_bank #(.IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .wr_en(wr_en), .idx(idx), .wdata(bus_wdata), .tc_reload(tc_reload),
    .copy_o(copy_v), .shadow_o(shadow_v)
  );

  sri_status_ctl u_stat (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .ack_rd(ack_rd_ev), .cnt_wr(cnt_wr_ev),
    .ev_stat_set(ev_stat_set), .ev_stat_clr(ev_stat_clr), .ev_intr_set(ev_intr_set),
    .ev_seq_load(ev_seq_load), .ev_seq_val(ev_seq_val),
    .ev_flags_load(ev_flags_load), .ev_flags_val(ev_flags_val),
    .stat_q(stat_q), .cause_q(cause_q), .step_q(step_q), .flags_q(flags_q),
    .irq_o(irq_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         err_q <= 1'b0;
    else if (soft_rst)  err_q <= 1'b0;
    else if (oor_wr_ev) err_q <= 1'b1;
  end
  assign err_o = err_q;

  always_comb begin
    bus_rdata = '0;
    if (in_range) begin
      unique case (idx)
        IDX_W'(OFS_FIFO):  bus_rdata = fifo_rdata;
        IDX_W'(OFS_STAT):  bus_rdata = stat_q;
        IDX_W'(OFS_CAUSE): bus_rdata = cause_q;
        IDX_W'(OFS_STEP):  bus_rdata = step_q;
        IDX_W'(OFS_FLAGS): bus_rdata = flags_q;
        default:           bus_rdata = copy_v[idx];
      endcase
    end
  end

  assign wshadow_o = shadow_v;
endmodule

// File: rtl/sri_checker.sv
module sri_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        soft_rst,
  input logic        bus_rd,
  input logic        irq_o,
  input logic        err_o,
  input logic [7:0]  stat_q,
  input logic [7:0]  cause_q,
  input logic [7:0]  step_q,
  input logic [7:0]  flags_q,
  input logic        ack_rd_ev,
  input logic        cnt_wr_ev,
  input logic        oor_wr_ev,
  input logic        ro_wr_ev,
  input logic [7:0]  ev_stat_set,
  input logic [7:0]  ev_stat_clr,
  input logic [7:0]  ev_intr_set,
  input logic        ev_seq_load,
  input logic        ev_flags_load,
  input logic [127:0] wshadow_o
);
  logic quiet;
  assign quiet = (ev_stat_set == 8'h00) && (ev_stat_clr == 8'h00) &&
                 (ev_intr_set == 8'h00) && !ev_seq_load && !ev_flags_load;

  AST_IRQ_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == stat_q[7]); // R7

  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(ev_stat_set[7])); // R7

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rd_ev && !soft_rst && ev_stat_set == 8'h00 && ev_intr_set == 8'h00 && !ev_seq_load
    |=> cause_q == 8'h00 && step_q == 8'h04 && !stat_q[7] && !stat_q[4] && !irq_o); // R6

  AST_CNT_WR_TC: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_ev && !ev_stat_set[4] |=> !stat_q[4]); // R5

  AST_RO_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ro_wr_ev && !bus_rd && quiet && !soft_rst
    |=> $stable(stat_q) && $stable(cause_q) && $stable(step_q) && $stable(flags_q)); // R3

  AST_OOR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    oor_wr_ev && !soft_rst |=> $stable(wshadow_o) && err_o); // R10

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_o && !soft_rst |=> err_o); // R10

  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !irq_o && !err_o && stat_q == 8'h00 && cause_q == 8'h00 &&
                 wshadow_o == '0); // R9
endmodule

bind scsi_regfile_irq sri_checker u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .bus_rd(bus_rd),
  .irq_o(irq_o), .err_o(err_o),
  .stat_q(stat_q), .cause_q(cause_q), .step_q(step_q), .flags_q(flags_q),
  .ack_rd_ev(ack_rd_ev), .cnt_wr_ev(cnt_wr_ev), .oor_wr_ev(oor_wr_ev), .ro_wr_ev(ro_wr_ev),
  .ev_stat_set(ev_stat_set), .ev_stat_clr(ev_stat_clr), .ev_intr_set(ev_intr_set),
  .ev_seq_load(ev_seq_load), .ev_flags_load(ev_flags_load), .wshadow_o(wshadow_o)
);

// File: tb/scsi_regfile_irq_tb.sv
module scsi_regfile_irq_tb;
  localparam int AW = 8;
  localparam int SH = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0, soft_rst = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]    bus_wdata = '0, bus_rdata;
  logic [7:0]    fifo_rdata = 8'hC3;
  logic [7:0]    ev_stat_set = '0, ev_stat_clr = '0, ev_intr_set = '0;
  logic          ev_seq_load = 1'b0, ev_flags_load = 1'b0, tc_reload = 1'b0;
  logic [7:0]    ev_seq_val = '0, ev_flags_val = '0;
  logic          irq_o, err_o;
  logic [127:0]  wshadow_o;

  scsi_regfile_irq #(.ADDR_W(AW), .ADDR_SHIFT(SH)) u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fifo_rdata(fifo_rdata),
    .ev_stat_set(ev_stat_set), .ev_stat_clr(ev_stat_clr), .ev_intr_set(ev_intr_set),
    .ev_seq_load(ev_seq_load), .ev_seq_val(ev_seq_val),
    .ev_flags_load(ev_flags_load), .ev_flags_val(ev_flags_val),
    .tc_reload(tc_reload), .irq_o(irq_o), .err_o(err_o), .wshadow_o(wshadow_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // independent model
  logic [7:0] m_vis [16];
  logic [7:0] m_shd [16];
  logic [7:0] m_stat, m_cause, m_step, m_flags;
  logic       m_err;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 16; k++) begin m_vis[k] = 8'h00; m_shd[k] = 8'h00; end
    m_vis[8] = 8'h07; m_vis[14] = 8'h04;
    m_stat = 0; m_cause = 0; m_step = 0; m_flags = 0; m_err = 0;
  endtask

  function automatic logic [7:0] exp_rd(input int i);
    if (i > 15) return 8'h00;
    case (i)
      2: return fifo_rdata;
      4: return m_stat;
      5: return m_cause;
      6: return m_step;
      7: return m_flags;
      default: return m_vis[i];
    endcase
  endfunction

  function automatic logic [127:0] exp_shadow();
    logic [127:0] v = '0;
    for (int k = 0; k < 16; k++) v[k*8 +: 8] = m_shd[k];
    return v;
  endfunction

  task automatic wr(input int i, input logic [7:0] v, input int low = 0);
    @(negedge clk);
    bus_addr = AW'((i << SH) | low); bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (i < 16) begin
      m_shd[i] = v;
      if (i == 3 || i == 8 || i >= 11) m_vis[i] = v;
      if (i <= 1) m_stat = m_stat & 8'hEF;
    end else m_err = 1'b1;
  endtask

  task automatic rd_chk(input int i, input string req, input int low = 0);
    logic [7:0] e;
    e = exp_rd(i);
    @(negedge clk);
    bus_addr = AW'((i << SH) | low); bus_rd = 1'b1;
    #1 chk(req, {120'b0, bus_rdata}, {120'b0, e});
    @(negedge clk);
    bus_rd = 1'b0;
    if (i == 5) begin m_cause = 0; m_stat = m_stat & 8'h6F; m_step = 8'h04; end
  endtask

  task automatic ev(input logic [7:0] s, input logic [7:0] c, input logic [7:0] ic,
                    input logic sl, input logic [7:0] sv, input logic fl, input logic [7:0] fv);
    @(negedge clk);
    ev_stat_set = s; ev_stat_clr = c; ev_intr_set = ic;
    ev_seq_load = sl; ev_seq_val = sv; ev_flags_load = fl; ev_flags_val = fv;
    @(negedge clk);
    ev_stat_set = 0; ev_stat_clr = 0; ev_intr_set = 0; ev_seq_load = 0; ev_flags_load = 0;
    m_stat = (m_stat & ~c) | s; m_cause = m_cause | ic;
    if (sl) m_step = sv;
    if (fl) m_flags = fv;
  endtask

  task automatic chk_pins(input string req);
    chk({req, " irq"}, {127'b0, irq_o}, {127'b0, m_stat[7]});
    chk({req, " err"}, {127'b0, err_o}, {127'b0, m_err});
    chk({req, " shadow"}, wshadow_o, exp_shadow());
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2: reset values, sweep all slots (slot 5 read moves step, see R6)
    chk_pins("R2");
    for (int i = 0; i < 16; i++) rd_chk(i, "R2 reset sweep");

    // R1: low address bits ignored
    for (int low = 0; low < 4; low++) begin
      wr(11, 8'h50 + 8'(low), low);
      rd_chk(11, "R1 alias", 3 - low);
    end

    // R3 R4 R5 R11: write sweep then read sweep
    for (int i = 0; i < 16; i++) wr(i, 8'(i * 37 + 5));
    chk_pins("R3 R4 shadow sweep");
    for (int i = 0; i < 16; i++) rd_chk(i, "R3 R4 R11 read sweep");

    // R5: reload count bytes
    @(negedge clk); tc_reload = 1'b1;
    @(negedge clk); tc_reload = 1'b0;
    m_vis[0] = m_shd[0]; m_vis[1] = m_shd[1];
    rd_chk(0, "R5 reload lo");
    rd_chk(1, "R5 reload mid");

    // R8 R7: events raise interrupt
    ev(8'h91, 8'h00, 8'h18, 1'b1, 8'h03, 1'b1, 8'h22);
    chk_pins("R7 raise");
    rd_chk(4, "R8 status set");
    rd_chk(6, "R8 step load");
    rd_chk(7, "R8 flags load");
    // R3: writes to read-mapped slots leave them alone
    for (int i = 4; i < 8; i++) wr(i, 8'hF0 | 8'(i));
    chk_pins("R3 ro writes");
    rd_chk(4, "R3 status kept");
    rd_chk(7, "R3 flags kept");
    // R6: acknowledge
    rd_chk(5, "R6 cause returned");
    chk_pins("R6 irq dropped");
    rd_chk(4, "R6 status after ack");
    rd_chk(5, "R6 cause cleared");
    rd_chk(6, "R6 step forced");

    // R7: repeated set keeps line, clear drops it
    ev(8'h80, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00);
    chk_pins("R7 set");
    ev(8'h80, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00);
    chk_pins("R7 set again");
    ev(8'h00, 8'h80, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00);
    chk_pins("R7 clear");

    // R5: count writes clear transfer-complete, slot 2 write does not
    ev(8'h10, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00);
    wr(2, 8'h77);
    rd_chk(4, "R5 slot2 keeps tc");
    wr(0, 8'h12);
    rd_chk(4, "R5 lo clears tc");
    ev(8'h10, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00);
    wr(1, 8'h34);
    rd_chk(4, "R5 mid clears tc");
    rd_chk(0, "R5 lo read side untouched");

    // R8: event in the same cycle as an acknowledge wins
    ev(8'h80, 8'h00, 8'h40, 1'b0, 8'h00, 1'b0, 8'h00);
    @(negedge clk);
    bus_addr = AW'(5 << SH); bus_rd = 1'b1; ev_stat_set = 8'h80; ev_intr_set = 8'h08;
    #1 chk("R8 ack read value", {120'b0, bus_rdata}, {120'b0, m_cause});
    @(negedge clk);
    bus_rd = 1'b0; ev_stat_set = 0; ev_intr_set = 0;
    m_cause = 8'h08; m_stat = (m_stat & 8'h6F) | 8'h80; m_step = 8'h04;
    chk_pins("R8 irq kept");
    rd_chk(5, "R8 cause after ack");

    // R10: out-of-range reads, then writes
    ev(8'h00, 8'h00, 8'h21, 1'b0, 8'h00, 1'b0, 8'h00);
    for (int i = 16; i < 64; i++) rd_chk(i, "R10 oor read");
    chk_pins("R10 oor read no err");
    rd_chk(5, "R10 oor read no ack");
    for (int i = 16; i < 64; i++) begin
      wr(i, 8'hAA);
      chk_pins("R10 oor write");
    end
    for (int i = 0; i < 16; i++) rd_chk(i, "R10 slots untouched");

    // R9: soft reset beats a write and an event in the same cycle
    ev(8'h80, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00);
    @(negedge clk);
    soft_rst = 1'b1; bus_addr = AW'(11 << SH); bus_wdata = 8'hEE; bus_wr = 1'b1;
    ev_stat_set = 8'h80;
    @(negedge clk);
    soft_rst = 1'b0; bus_wr = 1'b0; ev_stat_set = 0;
    model_reset();
    chk_pins("R9 soft reset");
    for (int i = 0; i < 16; i++) rd_chk(i, "R9 reset values");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule